// File: doc/BRIEF.md
# Narrow-Access Write Coalescing Bridge

The bridge sits between a CPU-side register bus that issues 8-, 16- and 32-bit accesses and a peripheral whose register file only accepts whole, word-aligned 32-bit writes. Reads fetch the aligned word once and return the addressed byte or halfword lane. Narrow writes become a read of the aligned word, a lane merge, and one full-word write back.

One pair of peripheral words is treated specially. The transfer-geometry word at 0x04 holds a size half at 0x04 and a count half at 0x06. The issue word at 0x0C holds a mode half at 0x0C and a trigger half at 0x0E. Halfword writes to the size, count and mode halves never reach the peripheral. They are merged into two shadow words inside the bridge. A halfword write to the trigger half releases them in a fixed order. The geometry shadow is written first, if it is nonzero, and is then cleared. The issue word, built from the mode shadow plus the new trigger value, follows in the next cycle. When a slow peripheral clock is flagged, every peripheral write is followed by a programmable number of idle cycles before anything else happens.

The request channel is valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low for the whole time a fetch, merge, flush, spacing gap or pending read response is in progress. The requester must hold its request stable while `req_ready` is low. The read response channel is valid/ready as well. `rsp_valid` and `rsp_rdata` stay unchanged until `rsp_ready` is seen high, and no new request is taken in the meantime.

Top module: `sw_coalesce_bridge`

## Requirements
- R1: Every peripheral strobe carries an address with bits [1:0] zero, read and write strobes never coincide, and a 32-bit write (size code 2) reaches the peripheral as one write of exactly the given word.
- R2: A byte read (size code 0) fetches the aligned word with a single read strobe and returns bits [8*off+7 : 8*off] in rsp_rdata[7:0], with zeros above, where off is address bits [1:0].
- R3: A halfword read (size code 1) returns the fetched word shifted right by 8*off and masked to 16 bits.
- R4: A byte write reads the aligned word, replaces only the addressed byte lane, and writes the whole word back with one write strobe.
- R5: A halfword write to any offset other than 0x04, 0x06, 0x0C and 0x0E is a read-modify-write of the aligned word in which only the addressed 16-bit lane changes.
- R6: Halfword writes to 0x04 (lane [15:0]) and 0x06 (lane [31:16]) cause no peripheral access and are merged into the geometry shadow.
- R7: A halfword write to 0x0C causes no peripheral access and is merged into lane [15:0] of the issue shadow.
- R8: A halfword write to 0x0E with a nonzero geometry shadow writes that shadow to word 0x04, clears the shadow, and then writes word 0x0C = {trigger value, issue shadow [15:0]`}`. With the slow flag low, the two writes fall in consecutive cycles.
- R9: With the geometry shadow zero, a trigger write produces exactly one peripheral write. The issue shadow is not altered by a trigger write, so a later trigger reuses the last mode half.
- R10: Both shadows are zero after reset, so the first trigger write after reset with no staging gives one write of {value, 16'h0000} to word 0x0C.
- R11: With slow_i high, each peripheral write is followed by gap_i+1 cycles without strobes, so consecutive writes of one flush start gap_i+2 cycles apart, and req_ready stays low until the gap has ended.
- R12: req_ready is high only when no operation is in progress, and a read response holds rsp_valid and rsp_rdata stable until rsp_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_i | input | 1 | Peripheral clock is slow, so write spacing is enforced |
| gap_i | input | GW | Idle cycles inserted after each write when slow_i is high |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Bridge can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 = byte, 1 = halfword, 2 or 3 = word |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Write data, right-aligned for narrow writes |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Requester takes read data |
| rsp_rdata | output | 32 | Read data, right-aligned |
| per_rd_en | output | 1 | Peripheral word read strobe, data expected on the next cycle |
| per_wr_en | output | 1 | Peripheral word write strobe |
| per_addr | output | AW | Peripheral word address |
| per_wdata | output | 32 | Peripheral write data |
| per_rdata | input | 32 | Peripheral read data, registered one cycle after per_rd_en |

## Verification
The bench checks the lane arithmetic at every byte offset and at both halfword offsets. A wrong shift would return a neighbouring lane, and a missing mask would let upper bytes leak into the result. It stages size, count and mode halves and confirms that nothing reaches the peripheral until the trigger arrives. It then checks the two-write order, the clearing of the geometry shadow, and the reuse of the mode half on a later trigger. A design that forwarded staged halves, or that flushed in the wrong order, would show extra or misordered write records. A design that failed to clear the shadow would produce a second geometry write. The spacing between flush writes is measured in cycles with the slow flag both low and high, so a missing or off-by-one gap shows up as a wrong distance.

// File: rtl/swc_pkg.sv
package swc_pkg;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_MERGE, ST_WR_GEO, ST_WR_MAIN, ST_GAP, ST_RESP
  } state_e;

  function automatic logic [31:0] lane_mask(logic [1:0] sz, logic [1:0] off);
    logic [4:0] sh;
    sh = {off, 3'b000};
    case (sz)
      SZ_BYTE: return 32'h0000_00FF << sh;
      SZ_HALF: return 32'h0000_FFFF << sh;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] lane_extract(logic [31:0] w, logic [1:0] sz,
                                               logic [1:0] off);
    logic [31:0] s;
    s = w >> {off, 3'b000};
    case (sz)
      SZ_BYTE: return s & 32'h0000_00FF;
      SZ_HALF: return s & 32'h0000_FFFF;
      default: return s;
    endcase
  endfunction
endpackage

// File: rtl/swc_lane_merge.sv
module swc_lane_merge
  import swc_pkg::*;
(
  input  logic [31:0] base,
  input  logic [1:0]  size,
  input  logic [1:0]  off,
  input  logic [31:0] data,
  output logic [31:0] merged
);
  logic [31:0] mask;
  logic [31:0] shifted;

  always_comb begin
    mask    = lane_mask(size, off);
    shifted = data << {off, 3'b000};
    merged  = (base & ~mask) | (shifted & mask);
  end
endmodule

// File: rtl/swc_gap_timer.sv
module swc_gap_timer #(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [GW-1:0] load,
  output logic          busy
);
  logic [GW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (start)        cnt <= load;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/swc_shadow_bank.sv
module swc_shadow_bank (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        geo_we,
  input  logic        geo_clr,
  input  logic [31:0] geo_d,
  input  logic        iss_we,
  input  logic [31:0] iss_d,
  output logic [31:0] geo_q,
  output logic [31:0] iss_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      geo_q <= '0;
      iss_q <= '0;
    end else begin
      if (geo_clr)     geo_q <= '0;
      else if (geo_we) geo_q <= geo_d;
      if (iss_we)      iss_q <= iss_d;
    end
  end
endmodule

// File: rtl/sw_coalesce_bridge.sv
module sw_coalesce_bridge
  import swc_pkg::*;
#(
  parameter int AW       = 8,
  parameter int GW       = 8,
  parameter int GEO_LO   = 4,
  parameter int GEO_HI   = 6,
  parameter int MODE_OFF = 12,
  parameter int TRIG_OFF = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_i,
  input  logic [GW-1:0] gap_i,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [31:0]   rsp_rdata,
  output logic          per_rd_en,
  output logic          per_wr_en,
  output logic [AW-1:0] per_addr,
  output logic [31:0]   per_wdata,
  input  logic [31:0]   per_rdata
);
  localparam logic [AW-1:0] GEO_LO_A  = AW'(GEO_LO);
  localparam logic [AW-1:0] GEO_HI_A  = AW'(GEO_HI);
  localparam logic [AW-1:0] MODE_A    = AW'(MODE_OFF);
  localparam logic [AW-1:0] TRIG_A    = AW'(TRIG_OFF);
  localparam logic [AW-1:0] GEO_WORD  = {GEO_LO_A[AW-1:2], 2'b00};

  state_e        state;
  logic          op_write;
  logic [1:0]    op_size;
  logic [AW-1:0] op_addr;
  logic [31:0]   op_wdata;
  logic [AW-1:0] wr_addr;
  logic [31:0]   wr_word;
  logic          pend_main;
  logic [31:0]   rsp_q;

  logic          accept, is_half, hit_geo, hit_mode, hit_trig, is_word;
  logic [31:0]   geo_q, iss_q, req_base, req_merged, fetch_merged;
  logic          gap_busy;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign is_half   = (req_size == SZ_HALF);
  assign is_word   = (req_size[1] == 1'b1);
  assign hit_geo   = is_half && ((req_addr == GEO_LO_A) || (req_addr == GEO_HI_A));
  assign hit_mode  = is_half && (req_addr == MODE_A);
  assign hit_trig  = is_half && (req_addr == TRIG_A);
  assign req_base  = hit_geo ? geo_q : iss_q;

  swc_lane_merge u_req_merge (
    .base(req_base), .size(req_size), .off(req_addr[1:0]),
    .data(req_wdata), .merged(req_merged)
  );

  swc_lane_merge u_fetch_merge (
    .base(per_rdata), .size(op_size), .off(op_addr[1:0]),
    .data(op_wdata), .merged(fetch_merged)
  );

  swc_shadow_bank u_shadow (
    .clk(clk), .rst_n(rst_n),
    .geo_we(accept && req_write && hit_geo),
    .geo_clr(state == ST_WR_GEO),
    .geo_d(req_merged),
    .iss_we(accept && req_write && hit_mode),
    .iss_d(req_merged),
    .geo_q(geo_q), .iss_q(iss_q)
  );

  swc_gap_timer #(.GW(GW)) u_gap (
    .clk(clk), .rst_n(rst_n),
    .start(per_wr_en && slow_i),
    .load(gap_i),
    .busy(gap_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      op_write  <= 1'b0;
      op_size   <= '0;
      op_addr   <= '0;
      op_wdata  <= '0;
      wr_addr   <= '0;
      wr_word   <= '0;
      pend_main <= 1'b0;
      rsp_q     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          op_write  <= req_write;
          op_size   <= req_size;
          op_addr   <= req_addr;
          op_wdata  <= req_wdata;
          wr_addr   <= {req_addr[AW-1:2], 2'b00};
          pend_main <= 1'b0;
          if (!req_write)             state <= ST_FETCH;
          else if (hit_geo || hit_mode) state <= ST_IDLE;
          else if (hit_trig) begin
            wr_word <= req_merged;
            state   <= (geo_q != '0) ? ST_WR_GEO : ST_WR_MAIN;
          end else if (is_word) begin
            wr_word <= req_wdata;
            state   <= ST_WR_MAIN;
          end else                    state <= ST_FETCH;
        end
        ST_FETCH: state <= ST_MERGE;
        ST_MERGE: begin
          if (!op_write) begin
            rsp_q <= lane_extract(per_rdata, op_size, op_addr[1:0]);
            state <= ST_RESP;
          end else begin
            wr_word <= fetch_merged;
            state   <= ST_WR_MAIN;
          end
        end
        ST_WR_GEO: begin
          pend_main <= 1'b1;
          state     <= slow_i ? ST_GAP : ST_WR_MAIN;
        end
        ST_WR_MAIN: begin
          pend_main <= 1'b0;
          state     <= slow_i ? ST_GAP : ST_IDLE;
        end
        ST_GAP: if (!gap_busy) state <= pend_main ? ST_WR_MAIN : ST_IDLE;
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    per_rd_en = (state == ST_FETCH);
    per_wr_en = (state == ST_WR_GEO) || (state == ST_WR_MAIN);
    if (state == ST_WR_GEO)     per_addr = GEO_WORD;
    else if (state == ST_FETCH) per_addr = {op_addr[AW-1:2], 2'b00};
    else                        per_addr = wr_addr;
    per_wdata = (state == ST_WR_GEO) ? geo_q : wr_word;
  end

  assign rsp_valid = (state == ST_RESP);
  assign rsp_rdata = rsp_q;
endmodule

// File: rtl/swc_checks.sv
module swc_checks #(
  parameter int AW       = 8,
  parameter int GW       = 8,
  parameter int GEO_LO   = 4,
  parameter int GEO_HI   = 6,
  parameter int MODE_OFF = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slow_i,
  input logic [GW-1:0] gap_i,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [1:0]    req_size,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [31:0]   rsp_rdata,
  input logic          per_rd_en,
  input logic          per_wr_en,
  input logic [AW-1:0] per_addr
);
  logic staged;
  assign staged = req_valid && req_ready && req_write && (req_size == 2'd1) &&
                  ((req_addr == AW'(GEO_LO)) || (req_addr == AW'(GEO_HI)) ||
                   (req_addr == AW'(MODE_OFF)));

  a_r1_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (per_rd_en || per_wr_en) |-> (per_addr[1:0] == 2'b00));
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(per_rd_en && per_wr_en));
  a_r2_read_fetches: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> per_rd_en);
  a_r6_staged_silent: assert property (@(posedge clk) disable iff (!rst_n)
    staged |=> (!per_wr_en && !per_rd_en));
  a_r11_gap_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (per_wr_en && slow_i && (gap_i != '0)) |=> !per_wr_en);
  a_r12_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (per_rd_en || per_wr_en) |-> !req_ready);
  a_r12_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

bind sw_coalesce_bridge swc_checks #(
  .AW(AW), .GW(GW), .GEO_LO(GEO_LO), .GEO_HI(GEO_HI), .MODE_OFF(MODE_OFF)
) u_swc_checks (.*);

// File: tb/test_sw_coalesce_bridge.sv
`timescale 1ns/1ps
module test_sw_coalesce_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_i = 1'b0;
  logic [7:0]  gap_i = 8'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [7:0]  req_addr = 8'd0;
  logic [31:0] req_wdata = 32'd0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        per_rd_en, per_wr_en;
  logic [7:0]  per_addr;
  logic [31:0] per_wdata;
  logic [31:0] per_rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sw_coalesce_bridge i_sw_coalesce_bridge (
    .clk(clk), .rst_n(rst_n), .slow_i(slow_i), .gap_i(gap_i),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .per_rd_en(per_rd_en), .per_wr_en(per_wr_en), .per_addr(per_addr),
    .per_wdata(per_wdata), .per_rdata(per_rdata)
  );

  // Peripheral model: word register file, registered read, write log
  logic [31:0] mem [0:63];
  logic [7:0]  log_a [0:31];
  logic [31:0] log_d [0:31];
  int          log_c [0:31];
  int          nw = 0;
  int          cyc = 0;
  int          nrd = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (per_wr_en) begin
      mem[per_addr[7:2]] <= per_wdata;
      log_a[nw[4:0]] <= per_addr;
      log_d[nw[4:0]] <= per_wdata;
      log_c[nw[4:0]] <= cyc;
      nw <= nw + 1;
    end
    if (per_rd_en) begin
      per_rdata <= mem[per_addr[7:2]];
      nrd <= nrd + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] sz, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_size = sz; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
  endtask

  task automatic bus_read(input logic [1:0] sz, input logic [7:0] a, input int hold,
                          output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_size = sz; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (hold > 0) rsp_ready = 1'b0;
    while (!rsp_valid) @(negedge clk);
    d = rsp_rdata;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R12 response held while rsp_ready low", {31'd0, rsp_valid}, 32'd1);
      chk("R12 response data stable", rsp_rdata, d);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R12 req_ready after reset", {31'd0, req_ready}, 32'd1);
    chk("R12 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    chk("R1 no strobe after reset", {30'd0, per_rd_en, per_wr_en}, 32'd0);
  endtask

  task automatic t_r10_reset_shadow;
    int n0;
    n0 = nw;
    bus_write(2'd1, 8'h0E, 32'h0000_00AB);
    chk("R10 single write after reset", nw - n0, 1);
    chk("R10 write address", {24'd0, log_a[n0[4:0]]}, 32'h0C);
    chk("R10 write data", log_d[n0[4:0]], 32'h00AB_0000);
  endtask

  task automatic t_r1_word;
    int n0;
    n0 = nw;
    bus_write(2'd2, 8'h20, 32'hA1B2_C3D4);
    bus_write(2'd2, 8'h04, 32'h0000_0000);
    bus_write(2'd2, 8'h0C, 32'h0000_0000);
    chk("R1 three word writes", nw - n0, 3);
    chk("R1 word address", {24'd0, log_a[n0[4:0]]}, 32'h20);
    chk("R1 word data", log_d[n0[4:0]], 32'hA1B2_C3D4);
  endtask

  task automatic t_r2_r3_reads;
    logic [31:0] d;
    int r0;
    logic [31:0] exp_b [4];
    exp_b = '{32'hD4, 32'hC3, 32'hB2, 32'hA1};
    for (int k = 0; k < 4; k++) begin
      r0 = nrd;
      bus_read(2'd0, 8'h20 + 8'(k), 0, d);
      chk("R2 byte read lane", d, exp_b[k]);
      chk("R2 one read strobe", nrd - r0, 1);
    end
    bus_read(2'd1, 8'h20, 0, d);
    chk("R3 half read offset 0", d, 32'h0000_C3D4);
    bus_read(2'd1, 8'h22, 3, d);
    chk("R3 half read offset 2", d, 32'h0000_A1B2);
    bus_read(2'd2, 8'h20, 0, d);
    chk("R1 word read", d, 32'hA1B2_C3D4);
  endtask

  task automatic t_r4_byte_write;
    logic [31:0] d;
    int n0;
    n0 = nw;
    bus_write(2'd0, 8'h21, 32'h0000_005A);
    chk("R4 one write", nw - n0, 1);
    chk("R4 merged word", log_d[n0[4:0]], 32'hA1B2_5AD4);
    bus_read(2'd2, 8'h20, 0, d);
    chk("R4 readback", d, 32'hA1B2_5AD4);
  endtask

  task automatic t_r5_half_rmw;
    int n0;
    n0 = nw;
    bus_write(2'd1, 8'h22, 32'h0000_1234);
    chk("R5 one write", nw - n0, 1);
    chk("R5 merged word", log_d[n0[4:0]], 32'h1234_5AD4);
  endtask

  task automatic t_r6_r7_r8_flush;
    logic [31:0] d;
    int n0;
    n0 = nw;
    bus_write(2'd1, 8'h04, 32'h0000_0200);
    bus_write(2'd1, 8'h06, 32'h0000_0001);
    bus_write(2'd1, 8'h0C, 32'h0000_0011);
    chk("R6 R7 staged writes silent", nw - n0, 0);
    bus_read(2'd2, 8'h04, 0, d);
    chk("R6 geometry word untouched", d, 32'h0);
    bus_read(2'd2, 8'h0C, 0, d);
    chk("R7 issue word untouched", d, 32'h0);
    n0 = nw;
    bus_write(2'd1, 8'h0E, 32'h0000_1234);
    chk("R8 two writes", nw - n0, 2);
    chk("R8 first address", {24'd0, log_a[n0[4:0]]}, 32'h04);
    chk("R8 first data", log_d[n0[4:0]], 32'h0001_0200);
    chk("R8 second address", {24'd0, log_a[5'(n0 + 1)]}, 32'h0C);
    chk("R8 second data", log_d[5'(n0 + 1)], 32'h1234_0011);
    chk("R8 back-to-back", log_c[5'(n0 + 1)] - log_c[n0[4:0]], 1);
  endtask

  task automatic t_r9_reuse;
    int n0;
    n0 = nw;
    bus_write(2'd1, 8'h0E, 32'h0000_5678);
    chk("R9 single write after clear", nw - n0, 1);
    chk("R9 address", {24'd0, log_a[n0[4:0]]}, 32'h0C);
    chk("R9 mode half reused", log_d[n0[4:0]], 32'h5678_0011);
  endtask

  task automatic t_r11_slow;
    int n0;
    slow_i = 1'b1; gap_i = 8'd5;
    bus_write(2'd1, 8'h04, 32'h0000_0040);
    n0 = nw;
    bus_write(2'd1, 8'h0E, 32'h0000_0033);
    chk("R11 two writes", nw - n0, 2);
    chk("R11 spacing gap+2", log_c[5'(n0 + 1)] - log_c[n0[4:0]], 7);
    chk("R11 first data", log_d[n0[4:0]], 32'h0000_0040);
    chk("R11 second data", log_d[5'(n0 + 1)], 32'h0033_0011);
    slow_i = 1'b0; gap_i = 8'd0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_r10_reset_shadow;
    t_r1_word;
    t_r2_r3_reads;
    t_r4_byte_write;
    t_r5_half_rmw;
    t_r6_r7_r8_flush;
    t_r9_reuse;
    t_r11_slow;
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule